// File: doc/BRIEF.md
# Auto-DMA Stereo Streaming Writer

This block takes a 16-bit PCM stream from a host and writes it into a ring in sound RAM that belongs to one audio core. The host sends 512-word blocks (0x400 bytes). The first 256 words of each block are the left channel and the last 256 are the right channel. The block writes them into two separate regions of the core's input ring, at a write pointer that alternates between the two halves of each region. The playback side returns space through a credit input. The block stalls the host while no space is left. Each half-region it fills is compared with the interrupt addresses of all cores.

A transfer begins with a start pulse that gives a byte length and a start address. It begins only when this core's auto-streaming enable bit is set. A status pair reports whether the transfer is in flight or complete. A progress counter reports how many bytes have been consumed. Host bytes beyond the last whole block are never taken.

Top module: `adma_stereo_writer`

## Requirements
- R1: A start pulse opens a transfer only when `auto_ctrl[CORE_ID]` is 1 (core 0 uses value 1, core 1 uses value 2). Otherwise the pulse is ignored: `busy` stays 0 and `s_ready` stays 0. A start pulse while `busy` is 1 is also ignored.
- R2: When a transfer is accepted, `xfer_addr` latches `start_addr` with only bits 12 to 3 kept and every other bit cleared.
- R3: Reset clears `busy` and `done`. An accepted start sets `busy`=1 and `done`=0 on the next cycle. A transfer in flight ends when no block is open and fewer than 0x400 bytes remain. `busy` then falls to 0 and `done` rises to 1. `busy` and `done` are never 1 together.
- R4: `s_ready` is 1 only while `busy` is 1. A new block may open only when at least 0x400 bytes remain and the free-space count is above zero. Once a block has opened, `s_ready` stays available until all 512 of its words have been accepted.
- R5: The word accepted at index i of a block (i from 0 to 511) is written with `mem_we`=1 one cycle after its handshake. Its data is unchanged. Its address is 0x2000 + 0x400*CORE_ID + wp + i when i < 256, and 0x2200 + 0x400*CORE_ID + wp + (i-256) otherwise.
- R6: The write pointer wp is 0 after reset. It advances by 0x100 modulo 0x200 after each block, so it alternates 0, 0x100, 0, and so on. It keeps its value from one transfer to the next.
- R7: `progress` is cleared by an accepted start and rises by 0x400 after each completed block.
- R8: `free_words` is 0x400 after reset. A pulse on `credit_en` adds `credit_words`. Each completed block subtracts 0x200, and the result is floored at 0. The result saturates at 0x400. A credit and a block end in the same cycle are combined.
- R9: When the last word of a half is accepted, each core c is tested against that half's range. The range starts at 0x2000 + 0x400*CORE_ID + wp for the left half, or 0x2200 + 0x400*CORE_ID + wp for the right half, and ends 0x100 words later. If `irq_en[c]` is 1 and `irq_addr` of core c lies at or above the start and strictly below the end, `irq_hit[c]` pulses for one cycle on the next cycle, together with `irq_req`.
- R10: Bytes left over after the last whole block (fewer than 0x400) are never accepted. `s_ready` stays 0 and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_ctrl | input | NUM_CORES | Auto-streaming enable, one bit per core |
| xfer_start | input | 1 | Start pulse for a transfer |
| xfer_bytes | input | LEN_W | Transfer length in bytes |
| start_addr | input | ADDR_W | Start address supplied with the transfer |
| s_valid | input | 1 | Host word valid |
| s_data | input | DATA_W | Host PCM word |
| s_ready | output | 1 | Block accepts a host word |
| credit_en | input | 1 | Space return from playback |
| credit_words | input | FREE_W | Words returned with `credit_en` |
| irq_en | input | NUM_CORES | Interrupt-address test enable per core |
| irq_addr | input | NUM_CORES*ADDR_W | Interrupt address per core, core c at bits [c*ADDR_W +: ADDR_W] |
| mem_we | output | 1 | Sound RAM write strobe |
| mem_addr | output | ADDR_W | Sound RAM word address |
| mem_wdata | output | DATA_W | Sound RAM write data |
| irq_hit | output | NUM_CORES | One-cycle hit pulse per core |
| irq_req | output | 1 | Interrupt request pulse |
| busy | output | 1 | Transfer in flight |
| done | output | 1 | Transfer complete |
| progress | output | LEN_W | Bytes consumed in this transfer |
| xfer_addr | output | ADDR_W | Start address latched and masked at the start |
| free_words | output | FREE_W | Free-space count in words |

## Verification
The assertions rely on a few conditions on the inputs. `credit_words` never exceeds what the count can hold before saturation. `auto_ctrl` stays steady while a transfer is in flight. Each interrupt address lies within the sound RAM address width. The directed tests meet these conditions in four ways. Credits go in only as single pulses of at most 0x300 words. The enable bits change only while the block is idle. Every interrupt address is placed exactly on, just inside, or just past a half-region boundary. Host valid is held high through stalls, so a stall shows up only in `s_ready` and never in the stimulus.

// File: rtl/adma_stream_pkg.sv
package adma_stream_pkg;
    // Shared sizing for the stereo streaming writer.
    localparam int unsigned SRAM_AW = 20;
    localparam int unsigned PCM_W   = 16;

    // Transfer status pair kept by the control unit.
    typedef struct packed {
        logic busy;
        logic done;
    } xfer_stat_t;
endpackage

// File: rtl/adma_credit.sv
// Free-space counter for the input ring.
// Counts free words. The playback side adds credits, and each finished
// block debits one block's worth. The result floors at zero and
// saturates at FREE_MAX.
// Assumes credit_words fits FREE_W and that block_end is a one-cycle pulse.
module adma_credit #(
    parameter int unsigned FREE_W   = 12,
    parameter int unsigned FREE_MAX = 1024,
    parameter int unsigned DEBIT    = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              credit_en,
    input  logic [FREE_W-1:0] credit_words,
    input  logic              block_end,
    output logic [FREE_W-1:0] free_words,
    output logic              has_room
);
    localparam int unsigned SUM_W = FREE_W + 2;

    logic [SUM_W-1:0] sum_inc;
    logic [SUM_W-1:0] sum_dec;
    logic [SUM_W-1:0] free_nxt;

    // Combine credit and debit, then clamp to the range 0..FREE_MAX.
    always_comb begin
        sum_inc = {2'b00, free_words} + (credit_en ? {2'b00, credit_words} : '0);
        if (block_end) begin
            sum_dec = (sum_inc >= SUM_W'(DEBIT)) ? (sum_inc - SUM_W'(DEBIT)) : '0;
        end else begin
            sum_dec = sum_inc;
        end
        free_nxt = (sum_dec > SUM_W'(FREE_MAX)) ? SUM_W'(FREE_MAX) : sum_dec;
    end

    // Register the free-space count; an empty ring is all free after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_words <= FREE_W'(FREE_MAX);
        end else begin
            free_words <= free_nxt[FREE_W-1:0];
        end
    end

    assign has_room = (free_words != '0);

    // R8
    free_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_words <= FREE_W'(FREE_MAX));

    // R8
    free_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!credit_en && !block_end) |=> $stable(free_words));
endmodule

// File: rtl/adma_addr_gen.sv
// Word counter and ring write pointer.
// Counts the words of the open block and forms the sound RAM address
// of the left or right half. The pointer advances by one half after
// each block.
// Assumes fire is asserted only while the control unit allows it.
module adma_addr_gen #(
    parameter int unsigned CORE_ID     = 0,
    parameter int unsigned HALF_WORDS  = 256,
    parameter int unsigned ADDR_W      = 20,
    parameter int unsigned RING_BASE   = 32'h2000,
    parameter int unsigned CORE_STRIDE = 32'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    output logic              in_block,
    output logic              half_end,
    output logic              block_end,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] half_base
);
    localparam int unsigned IDX_W = $clog2(2 * HALF_WORDS);
    localparam int unsigned OFF_W = IDX_W - 1;
    localparam logic [ADDR_W-1:0] CORE_BASE = ADDR_W'(RING_BASE + CORE_ID * CORE_STRIDE);
    localparam logic [ADDR_W-1:0] RIGHT_OFS = ADDR_W'(2 * HALF_WORDS);

    logic [IDX_W-1:0] word_cnt;
    logic [IDX_W-1:0] wr_ptr;
    logic             half_sel;
    logic [OFF_W-1:0] offs;

    assign half_sel = word_cnt[IDX_W-1];
    assign offs     = word_cnt[OFF_W-1:0];

    // Address of the current half and of the word inside it.
    always_comb begin
        half_base = CORE_BASE + (half_sel ? RIGHT_OFS : '0) + ADDR_W'(wr_ptr);
        cur_addr  = half_base + ADDR_W'(offs);
    end

    assign in_block  = (word_cnt != '0);
    assign half_end  = fire && (&offs);
    assign block_end = half_end && half_sel;

    // Advance the word index on each handshake; it wraps at block size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_cnt <= '0;
        end else if (fire) begin
            word_cnt <= word_cnt + IDX_W'(1);
        end
    end

    // Move the ring pointer by one half after every finished block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (block_end) begin
            wr_ptr <= wr_ptr + IDX_W'(HALF_WORDS);
        end
    end

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        block_end |=> (wr_ptr != $past(wr_ptr)));

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(word_cnt));
endmodule

// File: rtl/adma_irq_cmp.sv
// Interrupt-address test for each half-region written.
// When a half finishes, every core's interrupt address is compared
// with the half's word range [start, start + HALF_WORDS). Hits come
// out as registered one-cycle pulses.
// Assumes half_base holds the start of the half that is finishing.
module adma_irq_cmp #(
    parameter int unsigned NUM_CORES  = 2,
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned HALF_WORDS = 256
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        half_end,
    input  logic [ADDR_W-1:0]           half_base,
    input  logic [NUM_CORES-1:0]        irq_en,
    input  logic [NUM_CORES*ADDR_W-1:0] irq_addr,
    output logic [NUM_CORES-1:0]        irq_hit,
    output logic                        irq_req
);
    logic [ADDR_W:0]        half_limit;
    logic [NUM_CORES-1:0]   hit_now;

    assign half_limit = {1'b0, half_base} + (ADDR_W + 1)'(HALF_WORDS);

    // One range comparator per core.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [ADDR_W-1:0] tap;
        assign tap        = irq_addr[c*ADDR_W +: ADDR_W];
        assign hit_now[c] = irq_en[c] && (tap >= half_base) && ({1'b0, tap} < half_limit);
    end

    // Register hits only on the cycle a half completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_hit <= '0;
            irq_req <= 1'b0;
        end else begin
            irq_hit <= half_end ? hit_now : '0;
            irq_req <= half_end && (|hit_now);
        end
    end

    // R9
    hit_after_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_hit) |-> $past(half_end));

    // R9
    hit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_hit) |-> ((irq_hit & ~$past(irq_en)) == '0));
endmodule

// File: rtl/adma_ctrl.sv
// Transfer control for the streaming writer.
// Accepts a start when auto mode is set for this core, tracks the bytes
// remaining and the progress, and keeps the busy/done status pair.
// It also decides whether the host may hand over a word.
// Assumes block_end is a pulse from the address generator.
module adma_ctrl
    import adma_stream_pkg::*;
#(
    parameter int unsigned NUM_CORES   = 2,
    parameter int unsigned CORE_ID     = 0,
    parameter int unsigned LEN_W       = 16,
    parameter int unsigned ADDR_W      = 20,
    parameter int unsigned BLOCK_BYTES = 1024,
    parameter int unsigned AUTO_AW     = 13,
    parameter int unsigned ALIGN_BITS  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] auto_ctrl,
    input  logic                 xfer_start,
    input  logic [LEN_W-1:0]     xfer_bytes,
    input  logic [ADDR_W-1:0]    start_addr,
    input  logic                 in_block,
    input  logic                 has_room,
    input  logic                 block_end,
    output logic                 busy,
    output logic                 done,
    output logic [LEN_W-1:0]     progress,
    output logic [ADDR_W-1:0]    xfer_addr,
    output logic                 may_take
);
    localparam logic [NUM_CORES-1:0] CORE_MASK = NUM_CORES'(1) << CORE_ID;
    localparam logic [ADDR_W-1:0] ADDR_KEEP =
        ADDR_W'(((1 << AUTO_AW) - 1) & ~((1 << ALIGN_BITS) - 1));

    xfer_stat_t       stat;
    logic [LEN_W-1:0] remain;
    logic             auto_on;
    logic             accept;
    logic             enough;
    logic             finish;

    assign auto_on  = |(auto_ctrl & CORE_MASK);
    assign accept   = xfer_start && auto_on && !stat.busy;
    assign enough   = (remain >= LEN_W'(BLOCK_BYTES));
    assign finish   = stat.busy && !in_block && !enough;
    assign may_take = stat.busy && (in_block || (has_room && enough));
    assign busy     = stat.busy;
    assign done     = stat.done;

    // Status pair: set busy on accept, swap to done at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '{busy: 1'b0, done: 1'b0};
        end else if (accept) begin
            stat <= '{busy: 1'b1, done: 1'b0};
        end else if (finish) begin
            stat <= '{busy: 1'b0, done: 1'b1};
        end
    end

    // Byte accounting and latched start address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain    <= '0;
            progress  <= '0;
            xfer_addr <= '0;
        end else if (accept) begin
            remain    <= xfer_bytes;
            progress  <= '0;
            xfer_addr <= start_addr & ADDR_KEEP;
        end else if (block_end) begin
            remain    <= remain - LEN_W'(BLOCK_BYTES);
            progress  <= progress + LEN_W'(BLOCK_BYTES);
        end
    end

    // R3
    stat_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R4
    take_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        may_take |-> busy);

    // R4
    no_open_without_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_block && !has_room) |-> !may_take);

    // R1
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(xfer_start && auto_on)) |=> !busy);
endmodule

// File: rtl/adma_stereo_writer.sv
// Auto-DMA stereo streaming writer, top level.
// Splits each 512-word host block into a left half and a right half,
// writes them into this core's input ring in sound RAM, tracks free
// space from playback credits, and tests interrupt addresses for
// each half written.
// Assumes a valid/ready host stream and a sound RAM write port that
// takes one word per cycle.
module adma_stereo_writer
    import adma_stream_pkg::*;
#(
    parameter int unsigned NUM_CORES   = 2,
    parameter int unsigned CORE_ID     = 0,
    parameter int unsigned ADDR_W      = SRAM_AW,
    parameter int unsigned DATA_W      = PCM_W,
    parameter int unsigned LEN_W       = 16,
    parameter int unsigned FREE_W      = 12,
    parameter int unsigned HALF_WORDS  = 256,
    parameter int unsigned FREE_MAX    = 1024,
    parameter int unsigned RING_BASE   = 32'h2000,
    parameter int unsigned CORE_STRIDE = 32'h400
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CORES-1:0]        auto_ctrl,
    input  logic                        xfer_start,
    input  logic [LEN_W-1:0]            xfer_bytes,
    input  logic [ADDR_W-1:0]           start_addr,
    input  logic                        s_valid,
    input  logic [DATA_W-1:0]           s_data,
    output logic                        s_ready,
    input  logic                        credit_en,
    input  logic [FREE_W-1:0]           credit_words,
    input  logic [NUM_CORES-1:0]        irq_en,
    input  logic [NUM_CORES*ADDR_W-1:0] irq_addr,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    output logic [NUM_CORES-1:0]        irq_hit,
    output logic                        irq_req,
    output logic                        busy,
    output logic                        done,
    output logic [LEN_W-1:0]            progress,
    output logic [ADDR_W-1:0]           xfer_addr,
    output logic [FREE_W-1:0]           free_words
);
    localparam int unsigned BLOCK_WORDS = 2 * HALF_WORDS;
    localparam int unsigned BLOCK_BYTES = 2 * BLOCK_WORDS;
    localparam logic [ADDR_W-1:0] CORE_BASE = ADDR_W'(RING_BASE + CORE_ID * CORE_STRIDE);
    localparam logic [ADDR_W-1:0] CORE_TOP  = CORE_BASE + ADDR_W'(2 * BLOCK_WORDS);

    logic              fire;
    logic              in_block;
    logic              half_end;
    logic              block_end;
    logic              has_room;
    logic              may_take;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] half_base;

    assign s_ready = may_take;
    assign fire    = s_valid && may_take;

    adma_ctrl #(
        .NUM_CORES  (NUM_CORES),
        .CORE_ID    (CORE_ID),
        .LEN_W      (LEN_W),
        .ADDR_W     (ADDR_W),
        .BLOCK_BYTES(BLOCK_BYTES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_ctrl (auto_ctrl),
        .xfer_start(xfer_start),
        .xfer_bytes(xfer_bytes),
        .start_addr(start_addr),
        .in_block  (in_block),
        .has_room  (has_room),
        .block_end (block_end),
        .busy      (busy),
        .done      (done),
        .progress  (progress),
        .xfer_addr (xfer_addr),
        .may_take  (may_take)
    );

    adma_addr_gen #(
        .CORE_ID    (CORE_ID),
        .HALF_WORDS (HALF_WORDS),
        .ADDR_W     (ADDR_W),
        .RING_BASE  (RING_BASE),
        .CORE_STRIDE(CORE_STRIDE)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .in_block (in_block),
        .half_end (half_end),
        .block_end(block_end),
        .cur_addr (cur_addr),
        .half_base(half_base)
    );

    adma_credit #(
        .FREE_W  (FREE_W),
        .FREE_MAX(FREE_MAX),
        .DEBIT   (BLOCK_WORDS)
    ) u_credit (
        .clk         (clk),
        .rst_n       (rst_n),
        .credit_en   (credit_en),
        .credit_words(credit_words),
        .block_end   (block_end),
        .free_words  (free_words),
        .has_room    (has_room)
    );

    adma_irq_cmp #(
        .NUM_CORES (NUM_CORES),
        .ADDR_W    (ADDR_W),
        .HALF_WORDS(HALF_WORDS)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_end (half_end),
        .half_base(half_base),
        .irq_en   (irq_en),
        .irq_addr (irq_addr),
        .irq_hit  (irq_hit),
        .irq_req  (irq_req)
    );

    // Register the sound RAM write one cycle after each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= fire;
            if (fire) begin
                mem_addr  <= cur_addr;
                mem_wdata <= s_data;
            end
        end
    end

    // R5
    write_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> mem_we);

    // R5
    ring_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= CORE_BASE && mem_addr < CORE_TOP));

    // R10
    no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !mem_we);
endmodule

// File: tb/test_adma_stereo_writer.sv
module test_adma_stereo_writer;
    localparam int CORE = 1;
    localparam int AW   = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    auto_ctrl = '0;
    logic          xfer_start = 1'b0;
    logic [15:0]   xfer_bytes = '0;
    logic [AW-1:0] start_addr = '0;
    logic          s_valid = 1'b0;
    logic [15:0]   s_data = '0;
    logic          s_ready;
    logic          credit_en = 1'b0;
    logic [11:0]   credit_words = '0;
    logic [1:0]    irq_en = '0;
    logic [2*AW-1:0] irq_addr = '0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic [1:0]    irq_hit;
    logic          irq_req;
    logic          busy;
    logic          done;
    logic [15:0]   progress;
    logic [AW-1:0] xfer_addr;
    logic [11:0]   free_words;

    int checks = 0;
    int errors = 0;
    int wr_seen = 0;
    int wr_bad = 0;
    int hits0 = 0;
    int hits1 = 0;
    int reqs = 0;
    int exp_wp = 0;
    int exp_blk = 0;

    always #5 clk = ~clk;

    adma_stereo_writer #(.CORE_ID(CORE)) i_adma_stereo_writer (
        .clk(clk), .rst_n(rst_n), .auto_ctrl(auto_ctrl), .xfer_start(xfer_start),
        .xfer_bytes(xfer_bytes), .start_addr(start_addr), .s_valid(s_valid),
        .s_data(s_data), .s_ready(s_ready), .credit_en(credit_en),
        .credit_words(credit_words), .irq_en(irq_en), .irq_addr(irq_addr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .irq_hit(irq_hit), .irq_req(irq_req), .busy(busy), .done(done),
        .progress(progress), .xfer_addr(xfer_addr), .free_words(free_words)
    );

    // Write and interrupt monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (mem_we) begin
            int idx;
            int ea;
            idx = wr_seen;
            ea = 32'h2000 + CORE * 32'h400 + ((idx >= 256) ? 32'h200 : 0) + exp_wp + (idx % 256);
            if (mem_addr != AW'(ea) || mem_wdata != {exp_blk[3:0], idx[11:0]}) wr_bad++;
            wr_seen++;
        end
        if (irq_hit[0]) hits0++;
        if (irq_hit[1]) hits1++;
        if (irq_req) reqs++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic start_xfer(input logic [1:0] ac, input int len, input int addr);
        @(negedge clk);
        auto_ctrl  = ac;
        xfer_bytes = 16'(len);
        start_addr = AW'(addr);
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic give_credit(input int words);
        @(negedge clk);
        credit_en = 1'b1;
        credit_words = 12'(words);
        @(negedge clk);
        credit_en = 1'b0;
    endtask

    task automatic clear_counts();
        wr_seen = 0; wr_bad = 0; hits0 = 0; hits1 = 0; reqs = 0;
    endtask

    // Push one 512-word block; each word carries the block number and index.
    task automatic send_block(input int blk, input int wp);
        int i;
        clear_counts();
        exp_wp = wp;
        exp_blk = blk;
        i = 0;
        while (i < 512) begin
            @(negedge clk);
            s_valid = 1'b1;
            s_data = {4'(blk), 12'(i)};
            if (s_ready) i++;
        end
        @(negedge clk);
        s_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(wr_seen == 512 && wr_bad == 0, "R5/R6 block writes", wr_bad, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(busy == 0 && done == 0, "R3 reset status", {busy, done}, 0);
        check(s_ready == 0, "R4 reset ready", s_ready, 0);
        check(free_words == 12'h400, "R8 reset free", free_words, 32'h400);
    endtask

    task automatic t_not_auto();
        start_xfer(2'b01, 32'h800, 0);
        @(negedge clk);
        check(busy == 0 && s_ready == 0, "R1 start ignored without enable", {busy, s_ready}, 0);
    endtask

    task automatic t_two_blocks();
        irq_en = 2'b11;
        irq_addr[0 +: AW]  = AW'(32'h2410);
        irq_addr[AW +: AW] = AW'(32'h2700);
        start_xfer(2'b10, 32'h800, 32'hFABCF);
        check(busy == 1 && done == 0, "R3 busy after start", {busy, done}, 2);
        check(xfer_addr == AW'(32'h0BC8), "R2 masked address", xfer_addr, 32'hBC8);
        check(progress == 0, "R7 progress cleared", progress, 0);
        send_block(1, 0);
        check(progress == 16'h400, "R7 progress after block 1", progress, 32'h400);
        check(free_words == 12'h200, "R8 free after block 1", free_words, 32'h200);
        check(hits0 == 1 && hits1 == 0 && reqs == 1, "R9 left hit core0", hits0 * 16 + hits1, 16);
        start_xfer(2'b10, 32'h400, 0);
        check(busy == 1, "R1 start while busy ignored", busy, 1);
        send_block(2, 32'h100);
        check(progress == 16'h800, "R7 progress after block 2", progress, 32'h800);
        check(free_words == 0, "R8 free drained", free_words, 0);
        check(hits0 == 0 && hits1 == 1, "R9 right hit core1", hits0 * 16 + hits1, 1);
        check(busy == 0 && done == 1, "R3 completion", {busy, done}, 1);
    endtask

    task automatic t_stall();
        int seen;
        irq_addr[0 +: AW]  = AW'(32'h2400);
        irq_addr[AW +: AW] = AW'(32'h2500);
        start_xfer(2'b10, 32'h400, 0);
        check(busy == 1 && done == 0, "R3 restart", {busy, done}, 2);
        clear_counts();
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            s_valid = 1'b1;
            if (s_ready) seen++;
        end
        @(negedge clk);
        s_valid = 1'b0;
        check(seen == 0 && wr_seen == 0, "R4 stall without room", seen + wr_seen, 0);
        check(progress == 0, "R7 no progress in stall", progress, 0);
        give_credit(32'h100);
        check(free_words == 12'h100, "R8 credit added", free_words, 32'h100);
        send_block(3, 0);
        check(free_words == 0, "R8 floor at zero", free_words, 0);
        check(hits0 == 1 && hits1 == 0, "R9 inclusive start, exclusive end", hits0 * 16 + hits1, 16);
    endtask

    task automatic t_saturate();
        give_credit(32'h300);
        check(free_words == 12'h300, "R8 credit 0x300", free_words, 32'h300);
        give_credit(32'h300);
        check(free_words == 12'h400, "R8 saturate", free_words, 32'h400);
    endtask

    task automatic t_leftover();
        int seen;
        irq_en = 2'b01;
        irq_addr[0 +: AW]  = AW'(32'h2700);
        irq_addr[AW +: AW] = AW'(32'h2710);
        start_xfer(2'b10, 32'h500, 0);
        send_block(4, 32'h100);
        check(hits0 == 1 && hits1 == 0, "R9 right start hit, disabled core silent", hits0 * 16 + hits1, 16);
        check(free_words == 12'h200, "R8 debit", free_words, 32'h200);
        check(busy == 0 && done == 1, "R10 ends with leftover", {busy, done}, 1);
        clear_counts();
        seen = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            s_valid = 1'b1;
            if (s_ready) seen++;
        end
        @(negedge clk);
        s_valid = 1'b0;
        @(negedge clk);
        check(seen == 0 && wr_seen == 0, "R10 leftover not taken", seen + wr_seen, 0);
        check(progress == 16'h400, "R7 progress excludes leftover", progress, 32'h400);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_not_auto();
        t_two_blocks();
        t_stall();
        t_saturate();
        t_leftover();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule